// File: doc/BRIEF.md
# Serial Configuration Port with Register File

This block is the control-side serial slave of a mixed-signal chip. A host frames each transaction with an active-low select, clocks it with a serial clock, and sends one instruction byte followed by one to four data bytes. The instruction says whether the transaction reads or writes, how many bytes follow, and at which register it starts. Written bytes land in a small file of 8-bit configuration registers. The file's contents are exported in parallel to the rest of the chip. Read bytes are shifted back to the host.

Register 0 controls the port itself. Bit 6 selects whether bits travel most significant or least significant first. Bit 7 selects whether read data returns on the shared data line (three-wire use) or on the dedicated output line (four-wire use). Bit 5 is a self-clearing soft reset for every other register. Bit 1 reflects an external lock-status input. Both serial lines are synchronous to the system clock and are oversampled, so edges of the serial clock are events and not clocks. The pads sit outside the block, so the shared line is split into input, output and enable.

Top module: `cfg_spi_port`

## Requirements
- R1: Input data is captured only at a rising edge of sclk_i. Read data changes only after a falling edge of sclk_i, so a bit stays constant while sclk_i is high.
- R2: Holding csb_i high ends any transaction. A partly received byte is discarded and does not reach the registers. The next low period of csb_i starts again with an instruction byte. Both output enables are low while csb_i is high.
- R3: The instruction byte is laid out as follows. Bit 7 is 1 for a read and 0 for a write. Bits 6:5 hold the number of data bytes minus one. Bits 4:0 hold the starting register address.
- R4: In a multi-byte transfer, each byte after the first uses the next address. The address goes up by one when the order is most significant bit first, and down by one when the order is least significant bit first. It wraps within 5 bits.
- R5: Register 0 bit 6 sets the bit order. At 0 (the reset value), bit 7 of every byte, the instruction included, travels first. At 1, bit 0 travels first. A new value takes effect from the next transaction.
- R6: Register 0 bit 7 sets where read data appears. At 0, it appears on sdo_o with sdo_oe_o high and sdio_oe_o low. At 1, it appears on sdio_o with sdio_oe_o high and sdo_oe_o low. The enable is active only during the data bytes of a read.
- R7: Writing register 0 with bit 5 set returns registers 1 and up to their defaults in the same cycle. Register 0 keeps the other written bits. Bit 5 is never stored and always reads 0.
- R8: While rst is high, every register takes its default, register 0 included. Register 1 defaults to 0x04 and every other register to 0x00. The port also returns to most significant bit first, with read data on sdo_o.
- R9: A read of register 0 returns lock_i in bit 1. Writes to bit 1 are dropped, so the stored and exported bit stays 0.
- R10: Addresses from NUM_REGS to 31 are not backed by a register. Writes to them change nothing, and reads return 0x00.
- R11: cfg_o carries register i on bits [8i+7:8i]. It shows a written byte from the clock after the rising edge that completes that byte.
- R12: Serial bits sent after the last counted data byte are ignored until csb_i goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also oversamples the serial lines |
| rst | input | 1 | Synchronous active-high hardware reset |
| csb_i | input | 1 | Active-low transaction select |
| sclk_i | input | 1 | Serial clock, synchronous to clk |
| sdio_i | input | 1 | Shared data line, pad input side |
| sdio_o | output | 1 | Shared data line, pad output side |
| sdio_oe_o | output | 1 | Drive enable for the shared data line |
| sdo_o | output | 1 | Dedicated read-data line |
| sdo_oe_o | output | 1 | Drive enable for the dedicated read-data line |
| lock_i | input | 1 | Lock status, read back in register 0 bit 1 |
| cfg_o | output | NUM_REGS*8 | All registers in parallel, register i at [8i+7:8i] |

## Verification
Every register is written with a different arithmetic pattern and then read back, once in each bit order. A swapped bit order or a wrong address decode therefore shows up as a different value, not just a missing one. Four-byte bursts starting near address 0 and near the top of the file show the direction of the address step, the wrap, and the zero read past the file. Reads are repeated with the shared-line return mode on, which tells the two output paths apart. The data line is also sampled on both sides of each rising edge, which separates launching on the falling edge from launching on the rising one. Aborted bytes, surplus bits, soft reset, the lock bit and the hardware reset are each run as their own transaction, and the exported vector is compared after each one.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 2;

    // control register bit positions
    localparam int C_BIDIR = 7;
    localparam int C_LSB   = 6;
    localparam int C_SRST  = 5;
    localparam int C_LOCK  = 1;
    localparam logic [BYTE_W-1:0] CTL_KEEP = ~((8'h1 << C_SRST) | (8'h1 << C_LOCK));

    typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_e;

    typedef struct packed {
        logic              is_read;
        logic [CNT_W-1:0]  extra;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic bidir;
        logic lsb_first;
    } port_mode_t;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        return (idx == 1) ? 8'h04 : 8'h00;
    endfunction

    function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a, input logic lsb);
        return lsb ? a - ADDR_W'(1) : a + ADDR_W'(1);
    endfunction

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur, input logic b,
                                                   input logic lsb);
        return lsb ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
    import cfg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csb_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  port_mode_t        mode_i,
    output logic              sclk_fall_o,
    output port_mode_t        mode_o,
    output logic              rd_phase_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              ld_en_o,
    output logic [ADDR_W-1:0] ld_addr_o
);

    logic              sclk_q;
    logic              sclk_rise;
    phase_e            phase;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] byte_nxt;
    instr_t            instr;
    instr_t            instr_nxt;
    port_mode_t        mode_q;
    logic              byte_end;
    logic [ADDR_W-1:0] step_addr;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_i;
    end

    assign sclk_rise   = sclk_i & ~sclk_q & ~csb_i;
    assign sclk_fall_o = ~sclk_i & sclk_q & ~csb_i;

    assign byte_nxt  = shift_in(shreg, sdi_i, mode_q.lsb_first);
    assign instr_nxt = instr_t'(byte_nxt);
    assign byte_end  = sclk_rise && (bit_cnt == 3'd7) && (phase != PH_DONE);
    assign step_addr = addr_step(instr.addr, mode_q.lsb_first);

    always_comb begin
        wr_en_o    = byte_end && (phase == PH_DATA) && !instr.is_read;
        wr_addr_o  = instr.addr;
        wr_data_o  = byte_nxt;
        ld_en_o    = byte_end && (((phase == PH_INSTR) && instr_nxt.is_read) ||
                                  ((phase == PH_DATA) && instr.is_read && (instr.extra != '0)));
        ld_addr_o  = (phase == PH_INSTR) ? instr_nxt.addr : step_addr;
        rd_phase_o = (phase == PH_DATA) && instr.is_read && !csb_i;
        mode_o     = mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            shreg   <= '0;
            instr   <= '0;
            mode_q  <= '0;
        end else if (csb_i) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            shreg   <= '0;
            instr   <= '0;
            mode_q  <= mode_i;
        end else if (sclk_rise && phase != PH_DONE) begin
            bit_cnt <= bit_cnt + 3'd1;
            shreg   <= byte_nxt;
            if (bit_cnt == 3'd7) begin
                if (phase == PH_INSTR) begin
                    instr <= instr_nxt;
                    phase <= PH_DATA;
                end else if (instr.extra == '0) begin
                    phase <= PH_DONE;
                end else begin
                    instr.extra <= instr.extra - CNT_W'(1);
                    instr.addr  <= step_addr;
                end
            end
        end
    end

    // R1: the bit counter moves only on a captured rising edge
    assert_sample_on_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (!csb_i && !sclk_rise) |=> $stable(bit_cnt));

    // R2: a high select always brings the port back to the instruction phase
    assert_abort_to_instr_R2: assert property (@(posedge clk) disable iff (rst)
        csb_i |=> (phase == PH_INSTR && bit_cnt == 3'd0));

endmodule

// File: rtl/cfg_spi_tx.sv
module cfg_spi_tx
    import cfg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_fall_i,
    input  logic              ld_en_i,
    input  logic [BYTE_W-1:0] ld_data_i,
    input  port_mode_t        mode_i,
    input  logic              rd_phase_i,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    logic [BYTE_W-1:0] buf_q;
    logic              tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            tx_q  <= 1'b0;
        end else if (ld_en_i) begin
            buf_q <= ld_data_i;
        end else if (sclk_fall_i && rd_phase_i) begin
            tx_q  <= mode_i.lsb_first ? buf_q[0] : buf_q[BYTE_W-1];
            buf_q <= mode_i.lsb_first ? {1'b0, buf_q[BYTE_W-1:1]} : {buf_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign sdio_o    = tx_q;
    assign sdo_o     = tx_q;
    assign sdio_oe_o = rd_phase_i && mode_i.bidir;
    assign sdo_oe_o  = rd_phase_i && !mode_i.bidir;

    // R1: the launched bit changes only after a falling serial edge
    assert_launch_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall_i |=> $stable(tx_q));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_spi_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [BYTE_W-1:0]          wr_data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    input  logic                       lock_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o,
    output port_mode_t                 mode_o
);

    logic srst;

    assign srst = wr_en_i && (wr_addr_i == '0) && wr_data_i[C_SRST];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [BYTE_W-1:0] q;
        logic              hit;
        assign hit = wr_en_i && (wr_addr_i == ADDR_W'(i));
        if (i == 0) begin : g_ctl
            always_ff @(posedge clk) begin
                if (rst)      q <= reg_default(i);
                else if (hit) q <= wr_data_i & CTL_KEEP;
            end
        end else begin : g_dat
            always_ff @(posedge clk) begin
                if (rst)       q <= reg_default(i);
                else if (hit)  q <= wr_data_i;
                else if (srst) q <= reg_default(i);
            end
        end
        assign regs_o[i*BYTE_W +: BYTE_W] = q;
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr_i == ADDR_W'(k)) rd_data_o = regs_o[k*BYTE_W +: BYTE_W];
        end
        if (rd_addr_i == '0) rd_data_o[C_LOCK] = lock_i;
    end

    assign mode_o = '{bidir: regs_o[C_BIDIR], lsb_first: regs_o[C_LSB]};

    // R8: hardware reset clears the control register
    assert_hw_reset_ctl_R8: assert property (@(posedge clk)
        rst |=> regs_o[BYTE_W-1:0] == reg_default(0));

    if (NUM_REGS > 1) begin : g_srst_chk
        // R7: soft reset restores the data registers
        assert_soft_reset_R7: assert property (@(posedge clk) disable iff (rst)
            srst |=> regs_o[2*BYTE_W-1:BYTE_W] == reg_default(1));
    end

endmodule

// File: rtl/cfg_spi_port.sv
module cfg_spi_port
    import cfg_spi_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       csb_i,
    input  logic                       sclk_i,
    input  logic                       sdio_i,
    output logic                       sdio_o,
    output logic                       sdio_oe_o,
    output logic                       sdo_o,
    output logic                       sdo_oe_o,
    input  logic                       lock_i,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

    localparam int MAX_REGS = 1 << ADDR_W;

    logic              sclk_fall;
    port_mode_t        mode_live;
    port_mode_t        mode_frame;
    logic              rd_phase;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic              ld_en;
    logic [ADDR_W-1:0] ld_addr;
    logic [BYTE_W-1:0] ld_data;

    initial begin
        if (NUM_REGS < 1 || NUM_REGS > MAX_REGS) $error("NUM_REGS out of range");
    end

    cfg_spi_frame u_frame (
        .clk         (clk),
        .rst         (rst),
        .csb_i       (csb_i),
        .sclk_i      (sclk_i),
        .sdi_i       (sdio_i),
        .mode_i      (mode_live),
        .sclk_fall_o (sclk_fall),
        .mode_o      (mode_frame),
        .rd_phase_o  (rd_phase),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .ld_en_o     (ld_en),
        .ld_addr_o   (ld_addr)
    );

    cfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (ld_addr),
        .lock_i    (lock_i),
        .rd_data_o (ld_data),
        .regs_o    (cfg_o),
        .mode_o    (mode_live)
    );

    cfg_spi_tx u_tx (
        .clk         (clk),
        .rst         (rst),
        .sclk_fall_i (sclk_fall),
        .ld_en_i     (ld_en),
        .ld_data_i   (ld_data),
        .mode_i      (mode_frame),
        .rd_phase_i  (rd_phase),
        .sdio_o      (sdio_o),
        .sdio_oe_o   (sdio_oe_o),
        .sdo_o       (sdo_o),
        .sdo_oe_o    (sdo_oe_o)
    );

    // R6: the shared line is driven only when the control register asks for it
    assert_sdio_mode_R6: assert property (@(posedge clk) disable iff (rst)
        sdio_oe_o |-> cfg_o[C_BIDIR]);

    // R6: the dedicated line is driven only in four-wire return mode
    assert_sdo_mode_R6: assert property (@(posedge clk) disable iff (rst)
        sdo_oe_o |-> !cfg_o[C_BIDIR]);

    // R2: no output is enabled while the select is high
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        csb_i |-> !(sdio_oe_o || sdo_oe_o));

endmodule

// File: tb/cfg_spi_port_tb.sv
module cfg_spi_port_tb;

    localparam int NR = 16;

    logic            clk = 1'b0;
    logic            rst, csb_i, sclk_i, sdio_i, lock_i;
    logic            sdio_o, sdio_oe_o, sdo_o, sdo_oe_o;
    logic [NR*8-1:0] cfg_o;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    bit   tb_lsb, tb_bidir;
    logic [7:0] exp_r [32];

    always #10 clk = ~clk;

    cfg_spi_port #(.NUM_REGS(NR)) u_dut (
        .clk(clk), .rst(rst), .csb_i(csb_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .lock_i(lock_i), .cfg_o(cfg_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] dflt(input int i);
        return (i == 1) ? 8'h04 : 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) exp_r[i] = (i < NR) ? dflt(i) : 8'h00;
        tb_lsb = 0;
        tb_bidir = 0;
    endtask

    function automatic logic [127:0] cfg_model();
        logic [127:0] v = '0;
        for (int i = 0; i < NR; i++) v[i*8 +: 8] = exp_r[i];
        return v;
    endfunction

    function automatic logic [7:0] rd_model(input int a);
        if (a >= NR) return 8'h00;
        if (a == 0)  return exp_r[0] | {6'b0, lock_i, 1'b0};
        return exp_r[a];
    endfunction

    function automatic int next_addr(input int a);
        return tb_lsb ? ((a + 31) % 32) : ((a + 1) % 32);
    endfunction

    task automatic model_write(input int a, input logic [7:0] d);
        if (a >= NR) return;
        if (a == 0) begin
            exp_r[0] = d & 8'hDD;
            if (d[5]) for (int i = 1; i < NR; i++) exp_r[i] = dflt(i);
        end else begin
            exp_r[a] = d;
        end
    endtask

    task automatic frame_begin();
        @(negedge clk);
        sclk_i = 0;
        csb_i  = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (2) @(negedge clk);
        csb_i = 1;
        repeat (4) @(negedge clk);
        tb_lsb   = exp_r[0][6];
        tb_bidir = exp_r[0][7];
    endtask

    task automatic send_byte(input logic [7:0] b, input int nbits, output logic [7:0] rb,
                             output bit all_sdio, output bit all_sdo, output bit stab);
        rb = '0; all_sdio = 1; all_sdo = 1; stab = 1;
        for (int i = 0; i < nbits; i++) begin
            int   idx;
            logic p1, p2;
            idx = tb_lsb ? i : 7 - i;
            sdio_i = b[idx];
            repeat (3) @(negedge clk);
            p1 = sdio_oe_o ? sdio_o : sdo_o;
            if (!sdio_oe_o) all_sdio = 0;
            if (!sdo_oe_o)  all_sdo  = 0;
            sclk_i = 1;
            repeat (2) @(negedge clk);
            p2 = sdio_oe_o ? sdio_o : sdo_o;
            if (p1 !== p2) stab = 0;
            rb[idx] = p1;
            @(negedge clk);
            sclk_i = 0;
        end
    endtask

    task automatic xfer(input bit rd, input int n, input int a, input logic [31:0] wd,
                        output logic [31:0] rdv, output bit oe_ok, output bit st_ok);
        logic [7:0] ins, rb;
        bit s1, s2, st;
        int ad;
        ins = {rd, 2'(n - 1), 5'(a)};
        rdv = '0; oe_ok = 1; st_ok = 1;
        frame_begin();
        send_byte(ins, 8, rb, s1, s2, st);
        ad = a;
        for (int k = 0; k < n; k++) begin
            send_byte(rd ? 8'h00 : wd[k*8 +: 8], 8, rb, s1, s2, st);
            rdv[k*8 +: 8] = rb;
            if (rd && (s1 != tb_bidir || s2 != !tb_bidir)) oe_ok = 0;
            if (rd && !st) st_ok = 0;
            if (!rd) model_write(ad, wd[k*8 +: 8]);
            ad = next_addr(ad);
        end
        frame_end();
    endtask

    task automatic wr(input int n, input int a, input logic [31:0] wd);
        logic [31:0] r;
        bit o, s;
        xfer(0, n, a, wd, r, o, s);
    endtask

    task automatic rd_chk(input int n, input int a, input string req);
        logic [31:0] r;
        bit o, s;
        int ad;
        bit m;
        ad = a;
        m  = tb_bidir;
        xfer(1, n, a, 32'h0, r, o, s);
        for (int k = 0; k < n; k++) begin
            chk(r[k*8 +: 8] === rd_model(ad), req, $sformatf("read addr %0d", ad),
                128'(r[k*8 +: 8]), 128'(rd_model(ad)));
            ad = next_addr(ad);
        end
        chk(o, "R6", $sformatf("enable choice bidir=%0d", m), 128'(o), 128'(1));
        chk(s, "R1", "read bit steady across rising edge", 128'(s), 128'(1));
    endtask

    task automatic cfg_chk(input string req, input string what);
        chk(cfg_o === cfg_model(), req, what, cfg_o, cfg_model());
    endtask

    initial begin
        logic [7:0] rb;
        bit s1, s2, st;
        rst = 1; csb_i = 1; sclk_i = 0; sdio_i = 0; lock_i = 0;
        model_reset();
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        cfg_chk("R8", "defaults after reset");
        chk(!sdio_oe_o && !sdo_oe_o, "R2", "enables idle", {sdio_oe_o, sdo_oe_o}, 0);

        // R3 R11: sweep every register, most significant bit first
        for (int a = 1; a < NR; a++) begin
            wr(1, a, 32'((a * 37 + 5) & 8'hFF));
            cfg_chk("R11", $sformatf("export after write %0d", a));
        end
        for (int a = 0; a < NR; a++) rd_chk(1, a, "R3");

        // R4: ascending bursts, including past the file end (R10)
        wr(4, 4, 32'hC3A55A3C);
        cfg_chk("R4", "ascending burst write");
        rd_chk(4, 3, "R4");
        rd_chk(4, 14, "R10");
        wr(1, 20, 32'h000000EE);
        cfg_chk("R10", "write beyond file ignored");
        rd_chk(1, 20, "R10");

        // R9: lock bit read-only
        lock_i = 1;
        rd_chk(1, 0, "R9");
        wr(1, 0, 32'h00000002);
        lock_i = 0;
        cfg_chk("R9", "lock bit not stored");
        rd_chk(1, 0, "R9");

        // R5: switch to least significant bit first and sweep again
        wr(1, 0, 32'h00000040);
        cfg_chk("R5", "order bit stored");
        for (int a = 1; a < NR; a++) wr(1, a, 32'((a * 91 + 3) & 8'hFF));
        cfg_chk("R5", "sweep in reversed order");
        for (int a = 0; a < NR; a++) rd_chk(1, a, "R5");
        wr(3, 9, 32'h00117799);
        cfg_chk("R4", "descending burst write");
        rd_chk(3, 1, "R4");

        // R6: three-wire return
        wr(1, 0, 32'h000000C0);
        rd_chk(2, 12, "R6");
        rd_chk(1, 0, "R6");
        wr(1, 0, 32'h00000000);
        rd_chk(1, 7, "R6");

        // R7: soft reset keeps control bits, restores others
        wr(1, 0, 32'h00000024);
        cfg_chk("R7", "soft reset");
        rd_chk(1, 0, "R7");

        // R2: abort inside a byte
        frame_begin();
        send_byte(8'h02, 8, rb, s1, s2, st);
        send_byte(8'hA5, 5, rb, s1, s2, st);
        frame_end();
        cfg_chk("R2", "partial byte discarded");
        wr(1, 2, 32'h0000005B);
        cfg_chk("R2", "next frame after abort");

        // R12: surplus bits after the counted bytes
        frame_begin();
        send_byte(8'h03, 8, rb, s1, s2, st);
        send_byte(8'h3C, 8, rb, s1, s2, st);
        model_write(3, 8'h3C);
        send_byte(8'hFF, 8, rb, s1, s2, st);
        frame_end();
        cfg_chk("R12", "surplus byte ignored");

        // R8: hardware reset clears the control register too
        wr(1, 0, 32'h000000D0);
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
        @(negedge clk);
        cfg_chk("R8", "hardware reset");
        rd_chk(1, 1, "R8");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule